// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Controller

This block sits next to a real-time clock's BCD time counters. It holds four alarm registers, one each for seconds, minutes, hours and date. On every time-update strobe it compares them with the current time. Each alarm register has a skip bit that removes its field from the comparison. A single comparator therefore covers a one-time alarm and alarms that repeat every second, minute, hour or day.

The block also keeps three event flags: alarm, watchdog and power-fail. It merges them onto one interrupt pin. Each source has an enable. The pin's active level is programmable. It can either hold while an enabled flag is set or give a fixed-length pulse for each new event.

Software reaches everything through a small synchronous register bus. Reading the flags register returns the flags and clears them.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all alarm registers, the control register and the flags read as 0. `reg_rdata` is 0 and `irq_pin` is 1, which is deasserted for the default active-low setting.
- R2: A write with `reg_wr` loads `reg_wdata` into the register at `reg_addr` on that clock edge. The map is: 0 seconds alarm, 1 minutes alarm, 2 hours alarm, 3 date alarm, 4 control. A read with `reg_rd` places the register's value before that edge on `reg_rdata` one edge later, and `reg_rdata` holds that value until the next read. Control readback is bits [4:0] with bits [7:5] returned as 0.
- R3: On an edge with `tick` high, the alarm flag (flags bit 0) is set when every included field matches. A field is included when its alarm bit 7 is 0, and it matches when alarm bits [6:0] equal the current-time bits [6:0]. Without `tick` the alarm flag is never set, even if the time matches.
- R4: An alarm register with bit 7 set to 1 is left out of the comparison. When all four have bit 7 set, every `tick` sets the alarm flag.
- R5: A read of address 5 returns `{5'b0, pfail, wdt, alarm}` and clears all three flags on the same edge. An event that arrives on the same edge as the read is kept set.
- R6: `wdt_event` sets flags bit 1 and `pfail_event` sets flags bit 2 on the next edge, whether or not the source is enabled.
- R7: Control bits 0, 1 and 2 enable the alarm, watchdog and power-fail sources. In level mode (control bit 4 = 0), `irq_pin` is asserted on the edge after any enabled flag is set and stays asserted until no enabled flag remains. A flag whose source is disabled never asserts the pin.
- R8: In pulse mode (control bit 4 = 1), a rising edge of any enabled flag (flag AND enable going from 0 to 1) asserts `irq_pin` for exactly PULSE_LEN cycles, starting one edge later. A repeated event while the flag is still set gives no new pulse.
- R9: Control bit 3 selects the active level. 1 means asserted high and 0 means asserted low. The pin follows a change of this bit on the next edge.
- R10: Writes to address 5, 6 or 7 change nothing. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tick | input | 1 | Time-updated strobe, one cycle |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current date, BCD |
| wdt_event | input | 1 | Watchdog expiry event |
| pfail_event | input | 1 | Power-fail event |
| irq_pin | output | 1 | Interrupt output |

## Verification
The bench goes after these corner cases, and each one names the failure it would expose:
- A time that matches while `tick` is low. A design that compares continuously would raise the alarm flag here.
- A skipped field that differs from the current time. A design that ignores the skip bit would miss this alarm.
- A flags read that coincides with a new event. A design that lets the clear win would lose that event.
- A repeated event while its flag is still set in pulse mode. A design that re-arms on every event would emit a second pulse.
- A pulse counter that is off by one would give a pulse one cycle too long or too short.
- A disabled source whose flag is set. A design that drops the per-source enables would assert the pin here.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int FIELD_W  = 8;
  localparam int NFIELD   = 4;
  localparam int NSRC     = 3;
  localparam int ADDR_W   = 3;
  localparam int SKIP_BIT = 7;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd5;

  localparam int SRC_ALARM = 0;
  localparam int SRC_WDT   = 1;
  localparam int SRC_PFAIL = 2;

  localparam int CTL_W     = 5;
  localparam int CTL_HIGH  = 3;
  localparam int CTL_PULSE = 4;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NFIELD  = 4,
  parameter int FIELD_W = 8
) (
  input  logic [NFIELD*FIELD_W-1:0] alarm_vec,
  input  logic [NFIELD*FIELD_W-1:0] now_vec,
  output logic                      hit
);
  logic [NFIELD-1:0] field_ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    // top bit of each alarm field removes it from the compare
    assign field_ok[i] = alarm_vec[i*FIELD_W + FIELD_W-1] |
                         (alarm_vec[i*FIELD_W +: FIELD_W-1] == now_vec[i*FIELD_W +: FIELD_W-1]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/event_flags.sv
module event_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_all,
  output logic [NSRC-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (clr_all ? '0 : flags) | set_vec;
  end
endmodule

// File: rtl/irq_driver.sv
module irq_driver #(
  parameter int NSRC      = 3,
  parameter int PULSE_LEN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] enables,
  input  logic            active_high,
  input  logic            pulse_mode,
  output logic            pin
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [NSRC-1:0] pend, pend_prev;
  logic [CW-1:0]   cnt;
  logic            fresh, act;

  assign pend  = flags & enables;
  assign fresh = |(pend & ~pend_prev);
  assign act   = pulse_mode ? (fresh || (cnt != '0)) : (|pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_prev <= '0;
      cnt       <= '0;
      pin       <= 1'b1;
    end else begin
      pend_prev <= pend;
      if (fresh)           cnt <= CW'(PULSE_LEN - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      pin <= active_high ? act : ~act;
    end
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_date,
  input  logic              wdt_event,
  input  logic              pfail_event,
  output logic              irq_pin
);
  localparam int VEC_W = NFIELD * FIELD_W;

  logic [VEC_W-1:0] alarm_vec;
  logic [VEC_W-1:0] now_vec;
  logic [CTL_W-1:0] ctrl_q;
  logic [NSRC-1:0]  flags_q;
  logic [NSRC-1:0]  set_vec;
  logic             hit, flag_rd;
  logic [7:0]       rd_mux;

  assign now_vec = {cur_date, cur_hour, cur_min, cur_sec};

  for (genvar i = 0; i < NFIELD; i++) begin : g_alarm_reg
    always_ff @(posedge clk) begin
      if (rst) alarm_vec[i*FIELD_W +: FIELD_W] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(i))
        alarm_vec[i*FIELD_W +: FIELD_W] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[CTL_W-1:0];
  end

  alarm_match #(.NFIELD(NFIELD), .FIELD_W(FIELD_W)) u_match (
    .alarm_vec(alarm_vec),
    .now_vec  (now_vec),
    .hit      (hit)
  );

  assign flag_rd = reg_rd && (reg_addr == ADDR_FLAGS);

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_ALARM] = tick && hit;
    set_vec[SRC_WDT]   = wdt_event;
    set_vec[SRC_PFAIL] = pfail_event;
  end

  event_flags #(.NSRC(NSRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .clr_all(flag_rd),
    .flags  (flags_q)
  );

  always_comb begin
    rd_mux = '0;
    if (int'(reg_addr) < NFIELD)
      rd_mux = alarm_vec[int'(reg_addr)*FIELD_W +: FIELD_W];
    else if (reg_addr == ADDR_CTRL)
      rd_mux[CTL_W-1:0] = ctrl_q;
    else if (reg_addr == ADDR_FLAGS)
      rd_mux[NSRC-1:0] = flags_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  irq_driver #(.NSRC(NSRC), .PULSE_LEN(PULSE_LEN)) u_drv (
    .clk        (clk),
    .rst        (rst),
    .flags      (flags_q),
    .enables    (ctrl_q[NSRC-1:0]),
    .active_high(ctrl_q[CTL_HIGH]),
    .pulse_mode (ctrl_q[CTL_PULSE]),
    .pin        (irq_pin)
  );
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_rd,
  input logic [2:0] reg_addr,
  input logic       tick,
  input logic       wdt_event,
  input logic       pfail_event,
  input logic [2:0] flags_q,
  input logic [4:0] ctrl_q,
  input logic       irq_pin
);
  p_flags_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd5 && !tick && !wdt_event && !pfail_event) |=> (flags_q == 3'b000));

  p_wdt_sets_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_event |=> flags_q[1]);

  p_alarm_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[0]) |-> $past(tick));

  p_level_assert_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[4] && |(flags_q & ctrl_q[2:0])) |=> (irq_pin == $past(ctrl_q[3])));

  p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[4] && !(|(flags_q & ctrl_q[2:0]))) |=> (irq_pin == !$past(ctrl_q[3])));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .tick(tick),
  .wdt_event(wdt_event), .pfail_event(pfail_event), .flags_q(flags_q),
  .ctrl_q(ctrl_q), .irq_pin(irq_pin)
);

// File: tb/alarm_irq_ctrl_tb.sv
module alarm_irq_ctrl_tb;
  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic       wdt_event = 1'b0, pfail_event = 1'b0;
  logic       irq_pin;

  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  alarm_irq_ctrl #(.PULSE_LEN(PL)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .wdt_event(wdt_event), .pfail_event(pfail_event), .irq_pin(irq_pin)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int       m_alm[4];
  bit [4:0] m_ctrl;
  bit [2:0] m_flags, m_prev;
  int       m_cnt;
  bit       m_pin;
  bit [7:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_alm[i]) m_alm[i] = 0;
      m_ctrl = 0; m_flags = 0; m_prev = 0; m_cnt = 0; m_pin = 1; m_rdata = 0;
    end else begin
      bit [2:0] pend, nf;
      bit fresh, act, match;
      int now[4];
      pend  = m_flags & m_ctrl[2:0];
      fresh = (pend & ~m_prev) != 0;
      act   = m_ctrl[4] ? (fresh || m_cnt > 0) : (pend != 0);
      if (fresh) m_cnt = PL - 1;
      else if (m_cnt > 0) m_cnt--;
      m_prev = pend;
      m_pin  = m_ctrl[3] ? act : !act;
      now[0] = cur_sec; now[1] = cur_min; now[2] = cur_hour; now[3] = cur_date;
      match = 1;
      for (int i = 0; i < 4; i++)
        if (!m_alm[i][7] && (m_alm[i] % 128) != (now[i] % 128)) match = 0;
      if (reg_rd) begin
        if (reg_addr < 4)       m_rdata = 8'(m_alm[reg_addr]);
        else if (reg_addr == 4) m_rdata = {3'b0, m_ctrl};
        else if (reg_addr == 5) m_rdata = {5'b0, m_flags};
        else                    m_rdata = 0;
      end
      nf = m_flags;
      if (reg_rd && reg_addr == 5) nf = 0;
      if (tick && match) nf[0] = 1;
      if (wdt_event)     nf[1] = 1;
      if (pfail_event)   nf[2] = 1;
      m_flags = nf;
      if (reg_wr) begin
        if (reg_addr < 4)       m_alm[reg_addr] = reg_wdata;
        else if (reg_addr == 4) m_ctrl = reg_wdata[4:0];
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R7 R8 R9 model pin", irq_pin, m_pin);
      chk("R2 R5 model rdata", reg_rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_rd = 1; reg_addr = 3'(a);
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic tk(input int s, input int m, input int h, input int d);
    cur_sec = 8'(s); cur_min = 8'(m); cur_hour = 8'(h); cur_date = 8'(d);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic wdt_ev();
    wdt_event = 1; @(negedge clk); wdt_event = 0;
  endtask

  task automatic pf_ev();
    pfail_event = 1; @(negedge clk); pfail_event = 0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < PL + 4; i++) begin
      @(negedge clk);
      if (irq_pin) n++;
    end
  endtask

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pin after reset", irq_pin, 1);
    for (int a = 0; a < 6; a++) begin
      rd(a, v); chk("R1 reset readback", v, 0);
    end
    // R2 writes and readback
    wr(0, 'h30); wr(1, 'h15); wr(2, 'h08); wr(3, 'h21); wr(4, 'h01);
    rd(0, v); chk("R2 sec alarm", v, 'h30);
    rd(3, v); chk("R2 date alarm", v, 'h21);
    rd(4, v); chk("R2 control", v, 'h01);
    wr(4, 'hE1);
    rd(4, v); chk("R2 control upper bits read 0", v, 'h01);
    // R3 match without tick does nothing
    cur_sec = 'h30; cur_min = 'h15; cur_hour = 'h08; cur_date = 'h21;
    repeat (3) @(negedge clk);
    chk("R3 no tick no alarm pin", irq_pin, 1);
    rd(5, v); chk("R3 no tick no flag", v, 0);
    // R3 mismatch with tick
    tk('h31, 'h15, 'h08, 'h21);
    @(negedge clk);
    chk("R3 mismatch pin", irq_pin, 1);
    // R3 exact match
    tk('h30, 'h15, 'h08, 'h21);
    @(negedge clk);
    chk("R3 R7 match asserts active-low pin", irq_pin, 0);
    rd(5, v); chk("R5 flags read value", v, 'h01);
    @(negedge clk);
    chk("R7 pin released after clear", irq_pin, 1);
    rd(5, v); chk("R5 flags cleared", v, 0);
    // R4 skipped seconds field
    wr(0, 'hB0);
    tk('h45, 'h15, 'h08, 'h21);
    rd(5, v); chk("R4 skipped field matches", v, 'h01);
    // R4 all fields skipped
    wr(0, 'h80); wr(1, 'h80); wr(2, 'h80); wr(3, 'h80);
    tk('h07, 'h59, 'h23, 'h31);
    rd(5, v); chk("R4 every tick, first", v, 'h01);
    tk('h08, 'h59, 'h23, 'h31);
    rd(5, v); chk("R4 every tick, second", v, 'h01);
    // R6 R7 disabled watchdog source
    wdt_ev();
    repeat (2) @(negedge clk);
    chk("R7 disabled source no pin", irq_pin, 1);
    rd(5, v); chk("R6 watchdog flag set", v, 'h02);
    // R5 event during flags read is kept
    wdt_ev();
    reg_rd = 1; reg_addr = 3'd5; pfail_event = 1;
    @(negedge clk);
    reg_rd = 0; pfail_event = 0;
    chk("R5 read returns old flags", reg_rdata, 'h02);
    rd(5, v); chk("R5 same-cycle event kept", v, 'h04);
    // R9 polarity switch in level mode
    wr(4, 'h04);
    pf_ev();
    @(negedge clk);
    chk("R6 R7 power-fail asserts low", irq_pin, 0);
    wr(4, 'h0C);
    @(negedge clk);
    chk("R9 active-high asserts high", irq_pin, 1);
    rd(5, v); chk("R6 power-fail flag", v, 'h04);
    // R8 pulse mode, active high
    wr(4, 'h1F);
    @(negedge clk);
    chk("R9 deasserted active-high idle", irq_pin, 0);
    wdt_ev();
    count_high(n); chk("R8 pulse length", n, PL);
    wdt_ev();
    count_high(n); chk("R8 no re-pulse while flag set", n, 0);
    rd(5, v); chk("R8 flag still set", v, 'h02);
    pf_ev();
    count_high(n); chk("R8 second pulse after clear", n, PL);
    rd(5, v);
    // R10 ignored writes
    wr(4, 'h01);
    wdt_ev();
    wr(5, 'h00);
    rd(5, v); chk("R10 flags write ignored", v, 'h02);
    wr(6, 'hFF); wr(7, 'hFF);
    rd(6, v); chk("R10 addr 6 reads 0", v, 0);
    rd(7, v); chk("R10 addr 7 reads 0", v, 0);
    rd(0, v); chk("R10 alarm reg untouched", v, 'h80);
    rd(4, v); chk("R10 control untouched", v, 'h01);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule